// File: doc/BRIEF.md
# M/N/D Fractional Root Clock Generator

This block generates a derived clock from one of up to eight source clocks. Each source is presented as a tick input that pulses for one system cycle on every edge of that source (two ticks per source period). The chosen source is divided by an integer or half-integer pre-divider. The result can then be thinned by an M/N fractional accumulator whose duty cycle is set by a doubled D threshold. The block runs entirely on the system clock `clk`, so the output `clk_out` is a level that changes only on system clock edges.

Software writes settings into shadow registers through a simple register port. Nothing written there reaches the generator until bit 0 of the command register is set. That bit reads back as 1 until the shadow settings have been copied into the active set. The copy happens on the next boundary of the running divided period, so the output never carries a partial period of a mixed setting. Typical source codes are 0 for the crystal reference, 1 for the PLL main output and 6 for the PLL even output. With a 300 MHz source, divide-by-1, M=4, N=25 and 2D=25, the output is 48 MHz at roughly 50 % duty.

Top module: `mnd_root_clkgen`

## Requirements
- R1: After reset every shadow register and the update bit read 0. The generator runs from source 0 divided by 1, and `clk_out` is 1 in the first cycle after reset.
- R2: The divider field f (config bits [4:0], value 2·div−1) makes one divided period last P = f+1 ticks of the selected source, with f=0 treated as f=1. Without M/N/D, `clk_out` is high for the first ceil(P/2) ticks of each period.
- R3: The source field (config bits [10:8]) selects which `src_tick` bit advances the generator. Ticks on any other bit leave `clk_out` and the divider phase unchanged.
- R4: Writes to the shadow registers do not change `clk_out` until an update is committed.
- R5: Writing 1 to command bit 0 sets the update bit. It reads 1 until the tick that ends the current divided period, then 0, and at that edge the shadow set becomes active with the divider phase and accumulator cleared. Writing 0 to the bit has no effect.
- R6: M/N/D operation is on only when the mode field (config bits [13:12]) equals 2 and M is nonzero. Otherwise the plain divider output of R2 is used.
- R7: In M/N/D operation the M register holds M, the N register holds ~(N−M) and the D register holds ~(2D), each 16 bits. Each divided period adds M to an accumulator modulo N. `clk_out` is high while 2·accumulator < 2D, giving an output rate of M/N of the divided rate.
- R8: An update command written in the same cycle as a commit re-arms the update bit. The bit stays 1 and commits again at the next period boundary.
- R9: Register addresses are 0 command, 1 config, 2 M, 3 N, 4 D. Config reads back only its defined fields, M/N/D read back their low 16 bits, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | NSRC | One pulse per edge of each source clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| clk_out | output | 1 | Generated clock level |

## Verification
The two functions that can meet in one cycle are the commit of a pending update and a fresh update command from software. The bench counts ticks so that it writes the command exactly on the tick that closes a divided period. It judges the outcome by reading the update bit: it must still be 1 afterwards, stay 1 for three further ticks, and clear on the fourth tick of a divide-by-2 period. Output shape is judged by counting high samples and rising edges over whole periods of the selected source.

// File: rtl/rcgen_pkg.sv
package rcgen_pkg;
  localparam int CFG_DIV_LSB  = 0;
  localparam int CFG_DIV_W    = 5;
  localparam int CFG_SEL_LSB  = 8;
  localparam int CFG_SEL_W    = 3;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_MODE_W   = 2;
  localparam int CMD_UPD_BIT  = 0;

  localparam logic [CFG_MODE_W-1:0] MODE_DUAL = 2'd2;

  localparam int ADR_CMD = 0;
  localparam int ADR_CFG = 1;
  localparam int ADR_M   = 2;
  localparam int ADR_N   = 3;
  localparam int ADR_D   = 4;

  typedef struct packed {
    logic [CFG_MODE_W-1:0] mode;
    logic [CFG_SEL_W-1:0]  sel;
    logic [CFG_DIV_W-1:0]  div;
  } gen_cfg_t;
endpackage

// File: rtl/rcgen_regs.sv
module rcgen_regs
  import rcgen_pkg::*;
#(
  parameter int MND_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              commit_ok,
  output logic              commit,
  output gen_cfg_t          act_cfg,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADR_CMD);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADR_CFG);
  localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(ADR_M);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(ADR_N);
  localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(ADR_D);

  gen_cfg_t         shd_cfg_q, act_cfg_q;
  logic [MND_W-1:0] shd_m_q, shd_n_q, shd_d_q;
  logic [MND_W-1:0] act_m_q, act_n_q, act_d_q;
  logic             pending_q;
  logic             cmd_set;

  assign cmd_set = reg_wr && (reg_addr == A_CMD) && reg_wdata[CMD_UPD_BIT];
  assign commit  = pending_q && commit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_cfg_q <= '0;
      shd_m_q   <= '0;
      shd_n_q   <= '0;
      shd_d_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG: begin
          shd_cfg_q.div  <= reg_wdata[CFG_DIV_LSB +: CFG_DIV_W];
          shd_cfg_q.sel  <= reg_wdata[CFG_SEL_LSB +: CFG_SEL_W];
          shd_cfg_q.mode <= reg_wdata[CFG_MODE_LSB +: CFG_MODE_W];
        end
        A_M:     shd_m_q <= reg_wdata[MND_W-1:0];
        A_N:     shd_n_q <= reg_wdata[MND_W-1:0];
        A_D:     shd_d_q <= reg_wdata[MND_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      act_cfg_q <= '0;
      act_m_q   <= '0;
      act_n_q   <= '0;
      act_d_q   <= '0;
    end else begin
      pending_q <= (pending_q && !commit_ok) || cmd_set;
      if (commit) begin
        act_cfg_q <= shd_cfg_q;
        act_m_q   <= shd_m_q;
        act_n_q   <= shd_n_q;
        act_d_q   <= shd_d_q;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD: reg_rdata[CMD_UPD_BIT] = pending_q;
      A_CFG: begin
        reg_rdata[CFG_DIV_LSB +: CFG_DIV_W]   = shd_cfg_q.div;
        reg_rdata[CFG_SEL_LSB +: CFG_SEL_W]   = shd_cfg_q.sel;
        reg_rdata[CFG_MODE_LSB +: CFG_MODE_W] = shd_cfg_q.mode;
      end
      A_M:     reg_rdata[MND_W-1:0] = shd_m_q;
      A_N:     reg_rdata[MND_W-1:0] = shd_n_q;
      A_D:     reg_rdata[MND_W-1:0] = shd_d_q;
      default: ;
    endcase
  end

  assign act_cfg = act_cfg_q;
  assign act_m   = act_m_q;
  assign act_n   = act_n_q;
  assign act_d   = act_d_q;

  // R5
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_q) |-> $past(commit_ok));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending_q && commit_ok) |=> ($stable(act_cfg_q) && $stable(act_m_q)
                                   && $stable(act_n_q) && $stable(act_d_q)));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && commit_ok && cmd_set) |=> pending_q);
endmodule

// File: rtl/rcgen_prediv.sv
module rcgen_prediv #(
  parameter int NSRC  = 8,
  parameter int SEL_W = 3,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] divf,
  output logic             wrap,
  output logic             phase_hi
);
  localparam int CW = DIV_W + 1;

  logic          tick;
  logic [CW-1:0] per;
  logic [CW-1:0] cnt_q;
  logic          last;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) tick = src_tick[i];
    end
  end

  assign per      = (divf == '0) ? CW'(2) : (CW'(divf) + CW'(1));
  assign last     = (cnt_q == per - CW'(1));
  assign wrap     = tick && last;
  assign phase_hi = ({cnt_q, 1'b0} < {1'b0, per});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= last ? '0 : cnt_q + CW'(1);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per);
endmodule

// File: rtl/rcgen_mnd.sv
module rcgen_mnd #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         restart,
  input  logic [W-1:0] m,
  input  logic [W-1:0] nf,
  input  logic [W-1:0] df,
  output logic         level_hi
);
  logic [W-1:0] n_val, d2, acc_q, acc_d;
  logic [W:0]   sum;

  assign n_val    = ~nf + m;
  assign d2       = ~df;
  assign sum      = {1'b0, acc_q} + {1'b0, m};
  assign acc_d    = (sum >= {1'b0, n_val}) ? W'(sum - {1'b0, n_val}) : sum[W-1:0];
  assign level_hi = ({acc_q, 1'b0} < {1'b0, d2});

  always_ff @(posedge clk) begin
    if (!rst_n)           acc_q <= '0;
    else if (restart)     acc_q <= '0;
    else if (en && step)  acc_q <= acc_d;
  end

  // R7
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && (n_val > m) && (acc_q < n_val)) |=> (acc_q < $past(n_val)));

  // R6
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(acc_q));
endmodule

// File: rtl/mnd_root_clkgen.sv
module mnd_root_clkgen
  import rcgen_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int MND_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);
  gen_cfg_t         act_cfg;
  logic [MND_W-1:0] act_m, act_n, act_d;
  logic             commit, wrap, phase_hi, mnd_hi, mnd_en;

  rcgen_regs #(.MND_W(MND_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .commit_ok(wrap), .commit(commit),
    .act_cfg(act_cfg), .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  rcgen_prediv #(.NSRC(NSRC), .SEL_W(CFG_SEL_W), .DIV_W(CFG_DIV_W)) u_prediv (
    .clk(clk), .rst_n(rst_n),
    .src_tick(src_tick), .sel(act_cfg.sel), .divf(act_cfg.div),
    .wrap(wrap), .phase_hi(phase_hi)
  );

  assign mnd_en = (act_cfg.mode == MODE_DUAL) && (act_m != '0);

  rcgen_mnd #(.W(MND_W)) u_mnd (
    .clk(clk), .rst_n(rst_n),
    .en(mnd_en), .step(wrap), .restart(commit),
    .m(act_m), .nf(act_n), .df(act_d),
    .level_hi(mnd_hi)
  );

  assign clk_out = mnd_en ? mnd_hi : phase_hi;
endmodule

// File: tb/mnd_root_clkgen_tb_top.sv
module mnd_root_clkgen_tb_top;
  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_tick = '0;
  logic            reg_wr = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cur_src  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mnd_root_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_cyc(input logic [NSRC-1:0] mask);
    src_tick = mask;
    @(negedge clk);
    src_tick = '0;
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_tick(input int a, input int d, input logic [NSRC-1:0] mask);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d); src_tick = mask;
    @(negedge clk);
    reg_wr = 1'b0; src_tick = '0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  function automatic int cfgw(input int mode, input int sel, input int div);
    return (mode << 12) | (sel << 8) | div;
  endfunction

  // spec model: period of P ticks, optional M/N/D accumulator
  function automatic void model(input bit mnd, input int m, input int n, input int d2,
                                input int p, input int t, output int hi, output int ed);
    int cnt = 0;
    int acc = 0;
    bit prev, cur;
    hi = 0; ed = 0;
    prev = mnd ? (2*acc < d2) : (2*cnt < p);
    for (int i = 0; i < t; i++) begin
      cnt++;
      if (cnt == p) begin
        cnt = 0;
        if (mnd) acc = (acc + m) % n;
      end
      cur = mnd ? (2*acc < d2) : (2*cnt < p);
      if (cur) hi++;
      if (cur && !prev) ed++;
      prev = cur;
    end
  endfunction

  task automatic measure(input int src, input int t, output int hi, output int ed);
    bit prev;
    hi = 0; ed = 0;
    prev = clk_out;
    for (int i = 0; i < t; i++) begin
      tick_cyc(NSRC'(1) << src);
      if (clk_out) hi++;
      if (clk_out && !prev) ed++;
      prev = clk_out;
    end
  endtask

  task automatic apply_update(input string req);
    int v;
    wr(0, 1);
    rd(0, v);
    check({req, " update bit set"}, v & 1, 1);
    for (int i = 0; i < 200; i++) begin
      rd(0, v);
      if ((v & 1) == 0) break;
      tick_cyc(NSRC'(1) << cur_src);
    end
    rd(0, v);
    check({req, " update bit cleared"}, v & 1, 0);
  endtask

  task automatic t_reset();
    int v, hi, ed, ehi, eed;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1 reset readback", v, 0);
    end
    check("R1 clk_out after reset", int'(clk_out), 1);
    measure(0, 20, hi, ed);
    model(0, 0, 1, 0, 2, 20, ehi, eed);
    check("R1 reset divide-by-1 edges", ed, eed);
    check("R1 reset divide-by-1 highs", hi, ehi);
  endtask

  task automatic t_div();
    int fs[5] = '{1, 2, 4, 5, 0};
    int hi, ed, ehi, eed, p;
    foreach (fs[k]) begin
      wr(1, cfgw(0, 0, fs[k]));
      apply_update("R2");
      p = (fs[k] == 0) ? 2 : fs[k] + 1;
      measure(0, 60, hi, ed);
      model(0, 0, 1, 0, p, 60, ehi, eed);
      check($sformatf("R2 div field %0d edges", fs[k]), ed, eed);
      check($sformatf("R2 div field %0d highs", fs[k]), hi, ehi);
    end
  endtask

  task automatic t_shadow();
    int hi, ed, ehi, eed, v;
    wr(1, cfgw(0, 0, 5));
    apply_update("R4");
    wr(1, cfgw(0, 0, 1));
    rd(1, v);
    check("R9 cfg readback", v, cfgw(0, 0, 1));
    measure(0, 30, hi, ed);
    model(0, 0, 1, 0, 6, 30, ehi, eed);
    check("R4 shadow ignored edges", ed, eed);
    check("R4 shadow ignored highs", hi, ehi);
    apply_update("R4");
    measure(0, 30, hi, ed);
    model(0, 0, 1, 0, 2, 30, ehi, eed);
    check("R4 after commit edges", ed, eed);
  endtask

  task automatic t_sel();
    int hi, ed, ehi, eed;
    bit prev;
    wr(1, cfgw(0, 6, 3));
    apply_update("R3");
    cur_src = 6;
    hi = 0; ed = 0; prev = clk_out;
    for (int i = 0; i < 20; i++) begin
      tick_cyc(~(NSRC'(1) << 6));
      if (clk_out) hi++;
      if (clk_out != prev) ed++;
      prev = clk_out;
    end
    check("R3 other sources no toggles", ed, 0);
    check("R3 other sources level held", hi, 20);
    measure(6, 40, hi, ed);
    model(0, 0, 1, 0, 4, 40, ehi, eed);
    check("R3 selected source edges", ed, eed);
    check("R3 selected source highs", hi, ehi);
  endtask

  task automatic t_cmd();
    int v;
    wr(0, 0);
    rd(0, v);
    check("R5 write 0 no effect", v & 1, 0);
    wr(0, 1);
    for (int i = 0; i < 3; i++) begin
      tick_cyc(NSRC'(1) << 6);
      rd(0, v);
      check("R5 pending mid period", v & 1, 1);
    end
    tick_cyc(NSRC'(1) << 6);
    rd(0, v);
    check("R5 clears on period end", v & 1, 0);
  endtask

  task automatic t_collide();
    int v;
    wr(0, 1);
    for (int i = 0; i < 3; i++) tick_cyc(NSRC'(1) << 6);
    wr_tick(0, 1, NSRC'(1) << 6);
    rd(0, v);
    check("R8 rearm on commit cycle", v & 1, 1);
    for (int i = 0; i < 3; i++) begin
      tick_cyc(NSRC'(1) << 6);
      rd(0, v);
      check("R8 rearmed pending", v & 1, 1);
    end
    tick_cyc(NSRC'(1) << 6);
    rd(0, v);
    check("R8 second commit", v & 1, 0);
  endtask

  task automatic t_mnd(input int m, input int n, input int d2, input int t);
    int hi, ed, ehi, eed;
    wr(1, cfgw(2, 0, 1));
    wr(2, m);
    wr(3, (~(n - m)) & 32'hFFFF);
    wr(4, (~d2) & 32'hFFFF);
    apply_update("R7");
    cur_src = 0;
    measure(0, t, hi, ed);
    model(1, m, n, d2, 2, t, ehi, eed);
    check($sformatf("R7 M=%0d N=%0d edges", m, n), ed, eed);
    check($sformatf("R7 M=%0d N=%0d highs", m, n), hi, ehi);
  endtask

  task automatic t_mnd_off();
    int hi, ed, ehi, eed;
    wr(2, 0);
    apply_update("R6");
    measure(0, 20, hi, ed);
    model(0, 0, 1, 0, 2, 20, ehi, eed);
    check("R6 mode2 M=0 plain edges", ed, eed);
    check("R6 mode2 M=0 plain highs", hi, ehi);
    wr(1, cfgw(0, 0, 1));
    wr(2, 4);
    apply_update("R6");
    measure(0, 20, hi, ed);
    check("R6 mode0 with M plain edges", ed, eed);
    check("R6 mode0 with M plain highs", hi, ehi);
  endtask

  task automatic t_readback();
    int v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v);
    check("R9 cfg masked", v, 32'h371F);
    wr(2, 32'hABCD_1234);
    rd(2, v);
    check("R9 M 16-bit", v, 32'h1234);
    wr(5, 32'h5555_5555);
    rd(5, v);
    check("R9 unmapped reads 0", v, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div();
    t_shadow();
    t_sel();
    t_cmd();
    t_collide();
    t_mnd(4, 25, 25, 50);
    t_mnd(8, 75, 75, 150);
    t_mnd_off();
    t_readback();
    finish_run();
  end
endmodule